// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block rebuilds the four arithmetic condition flags (negative, zero, overflow, carry) from a deferred flag record. The record holds an operation class, a result word and one operand word. A pipeline that postpones flag work stores only that record after each instruction. When a later instruction needs the flags, it sends the record here. The carry and overflow are recovered from the result and the single operand, using a rule that belongs to the class.

The block also works as an extend-carrying adder and subtractor for multi-word arithmetic. In that mode it takes two operands, the incoming extend bit X and the zero flag of the previous word. It returns the result word, the new X (which is also C) and a zero flag that stays cleared once any word of the chain is non-zero. Each accepted request produces one registered response one clock later.

Top module: `lazy_flag_unit`

## Requirements
- R1: The flag output is packed as bit 4 = X, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. With class code 0 (pass-through), the flag output equals bits 4..0 of `in_a` unchanged.
- R2: For class codes 1 to 8, Z is set when the sized result is zero. N is set only when the sized result is non-zero with its top bit set. X is copied from `in_x`.
- R3: For class code 1 (logic), N and Z follow `in_a`, and V and C are zero.
- R4: For class code 2 (add), with result r = `in_a` and operand s = `in_b`, C = (r < s unsigned) and V is the top bit of (s ^ r) & ~((r - s) ^ s).
- R5: For class code 3 (subtract), the minuend m = r + s is rebuilt, C = (m < s unsigned) and V is the top bit of (m ^ r) & (m ^ s).
- R6: Class codes 4 (byte compare) and 5 (word compare) apply the subtract rule to bits 7..0 or 15..0 of both inputs only. Higher bits have no effect.
- R7: Class code 6 (add with extend) uses r <= s for C and r - s - 1 for the overflow rebuild. Class code 7 (subtract with extend) rebuilds m = r + s + 1, sets C = (m <= s) and takes V as in R5.
- R8: For class code 8 (shift), C is set exactly when `in_b` is non-zero, V is zero, and N and Z follow `in_a`.
- R9: Class codes 9 (chained add) and 10 (chained subtract) output a + b + X or a - (b + X) on `out_value`. The new X equals the carry or borrow and equals C. V follows the add or subtract overflow of the operation.
- R10: In class codes 9 and 10, the output Z is the fresh zero test of the result ANDed with `in_zprev`.
- R11: Class codes 11 to 15 produce all-zero flags, a zero value, and `out_err` high for exactly one cycle.
- R12: A request with `in_valid` high is answered one clock later with `out_valid` high. `out_value` is zero for classes 0 to 8. Synchronous reset clears `out_valid`, `out_flags`, `out_value` and `out_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_cls | input | 4 | Operation class code |
| in_a | input | W | Result word, or first operand in chained modes |
| in_b | input | W | Operand word, or second operand in chained modes |
| in_x | input | 1 | Incoming extend bit |
| in_zprev | input | 1 | Zero flag of the previous word in a chain |
| out_valid | output | 1 | Response strobe |
| out_flags | output | 5 | Packed {X,N,Z,V,C} |
| out_value | output | W | Chained-mode result word |
| out_err | output | 1 | Unknown class code pulse |

## Verification
Add and subtract records are built from real operand pairs: carry-out only, signed overflow only, both, and results that wrap to exactly zero. These tell apart the plain and extended carry comparisons, and they show whether the overflow rebuild uses the right XOR pattern. Byte and word compares carry random upper bits, which shows whether the narrow widths really ignore them. Two-word chains, one with an all-zero total and one whose low word is non-zero, separate the sticky zero from a fresh zero test. Shift records with zero and non-zero operands, pass-through words and unknown codes cover the remaining selection paths.

// File: rtl/lazy_flag_pkg.sv
package lazy_flag_pkg;
  localparam int FLAG_W = 5;
  localparam int CLS_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_PASS  = 4'd0,
    CLS_LOGIC = 4'd1,
    CLS_ADD   = 4'd2,
    CLS_SUB   = 4'd3,
    CLS_CMPB  = 4'd4,
    CLS_CMPW  = 4'd5,
    CLS_ADDX  = 4'd6,
    CLS_SUBX  = 4'd7,
    CLS_SHIFT = 4'd8,
    CLS_XADD  = 4'd9,
    CLS_XSUB  = 4'd10
  } flag_cls_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } flag_vec_t;
endpackage

// File: rtl/arith_flag_core.sv
// Rebuilds N, Z, V, C at width WD from a result and one operand.
module arith_flag_core #(
  parameter int WD = 32
) (
  input  logic [WD-1:0] res,
  input  logic [WD-1:0] opd,
  input  logic          is_sub,
  input  logic          ext,
  output logic          n,
  output logic          z,
  output logic          v,
  output logic          c
);
  logic [WD-1:0] ext_w;
  logic [WD-1:0] rebuilt;
  logic [WD-1:0] vbits;

  assign ext_w = {{(WD-1){1'b0}}, ext};

  always_comb begin
    z = (res == '0);
    n = !z && res[WD-1];
    if (is_sub) begin
      // minuend recovered from difference and subtrahend
      rebuilt = res + opd + ext_w;
      c       = ext ? (rebuilt <= opd) : (rebuilt < opd);
      vbits   = (rebuilt ^ res) & (rebuilt ^ opd);
    end else begin
      // first addend recovered from sum and second addend
      rebuilt = res - opd - ext_w;
      c       = ext ? (res <= opd) : (res < opd);
      vbits   = (opd ^ res) & ~(rebuilt ^ opd);
    end
    v = vbits[WD-1];
  end
endmodule

// File: rtl/flag_class_eval.sv
// Selects the per-class flag rule for a deferred record.
module flag_class_eval
  import lazy_flag_pkg::*;
#(
  parameter int W      = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [W-1:0]     res,
  input  logic [W-1:0]     opd,
  input  logic             x_in,
  output flag_vec_t        flags,
  output logic             known
);
  localparam int N_NARROW = 2;

  logic full_sub, full_ext;
  logic fn, fz, fv, fc;
  logic [N_NARROW-1:0] nn, nz, nv, nc;

  assign full_sub = (cls == CLS_SUB) || (cls == CLS_SUBX);
  assign full_ext = (cls == CLS_ADDX) || (cls == CLS_SUBX);
  assign known    = (cls <= CLS_SHIFT);

  arith_flag_core #(.WD(W)) u_full (
    .res(res), .opd(opd), .is_sub(full_sub), .ext(full_ext),
    .n(fn), .z(fz), .v(fv), .c(fc)
  );

  // narrow compare widths: index 0 byte, index 1 half-word
  for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
    localparam int NW = (g == 0) ? BYTE_W : HALF_W;
    arith_flag_core #(.WD(NW)) u_core (
      .res(res[NW-1:0]), .opd(opd[NW-1:0]), .is_sub(1'b1), .ext(1'b0),
      .n(nn[g]), .z(nz[g]), .v(nv[g]), .c(nc[g])
    );
  end

  always_comb begin
    flags = '0;
    case (cls)
      CLS_PASS:  flags = flag_vec_t'(res[FLAG_W-1:0]);
      CLS_LOGIC: flags = '{x: x_in, n: fn, z: fz, v: 1'b0, c: 1'b0};
      CLS_ADD, CLS_SUB, CLS_ADDX, CLS_SUBX:
                 flags = '{x: x_in, n: fn, z: fz, v: fv, c: fc};
      CLS_CMPB:  flags = '{x: x_in, n: nn[0], z: nz[0], v: nv[0], c: nc[0]};
      CLS_CMPW:  flags = '{x: x_in, n: nn[1], z: nz[1], v: nv[1], c: nc[1]};
      CLS_SHIFT: flags = '{x: x_in, n: fn, z: fz, v: 1'b0, c: |opd};
      default:   flags = '0;
    endcase
  end
endmodule

// File: rtl/ext_chain_adder.sv
// Extend-carrying add/subtract with a sticky zero across words.
module ext_chain_adder
  import lazy_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         x_in,
  input  logic         z_prev,
  input  logic         is_sub,
  output logic [W-1:0] sum,
  output flag_vec_t    flags
);
  logic [W-1:0] x_w;
  logic cn, cz, cv, cc;

  assign x_w = {{(W-1){1'b0}}, x_in};
  assign sum = is_sub ? (a - (b + x_w)) : (a + b + x_w);

  arith_flag_core #(.WD(W)) u_core (
    .res(sum), .opd(b), .is_sub(is_sub), .ext(x_in),
    .n(cn), .z(cz), .v(cv), .c(cc)
  );

  assign flags = '{x: cc, n: cn, z: cz & z_prev, v: cv, c: cc};
endmodule

// File: rtl/lazy_flag_unit.sv
module lazy_flag_unit
  import lazy_flag_pkg::*;
#(
  parameter int W      = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CLS_W-1:0]  in_cls,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_b,
  input  logic              in_x,
  input  logic              in_zprev,
  output logic              out_valid,
  output logic [FLAG_W-1:0] out_flags,
  output logic [W-1:0]      out_value,
  output logic              out_err
);
  flag_vec_t    eval_f, chain_f, next_f;
  logic         eval_known, is_chain, chain_sub, next_err;
  logic [W-1:0] chain_sum, next_val;

  assign is_chain  = (in_cls == CLS_XADD) || (in_cls == CLS_XSUB);
  assign chain_sub = (in_cls == CLS_XSUB);

  flag_class_eval #(.W(W), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_eval (
    .cls(in_cls), .res(in_a), .opd(in_b), .x_in(in_x),
    .flags(eval_f), .known(eval_known)
  );

  ext_chain_adder #(.W(W)) u_chain (
    .a(in_a), .b(in_b), .x_in(in_x), .z_prev(in_zprev), .is_sub(chain_sub),
    .sum(chain_sum), .flags(chain_f)
  );

  always_comb begin
    next_f   = '0;
    next_val = '0;
    next_err = 1'b0;
    if (is_chain) begin
      next_f   = chain_f;
      next_val = chain_sum;
    end else if (eval_known) begin
      next_f   = eval_f;
    end else begin
      next_err = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_flags <= '0;
      out_value <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid && next_err;
      if (in_valid) begin
        out_flags <= next_f;
        out_value <= next_val;
      end
    end
  end
endmodule

// File: rtl/lazy_flag_unit_chk.sv
module lazy_flag_unit_chk
  import lazy_flag_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [CLS_W-1:0]  in_cls,
  input logic [FLAG_W-1:0] in_a_lo,
  input logic [W-1:0]      in_b,
  input logic              in_x,
  input logic              in_zprev,
  input logic              out_valid,
  input logic [FLAG_W-1:0] out_flags,
  input logic [W-1:0]      out_value,
  input logic              out_err
);
  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_err));
  // R12
  nonchain_value_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls <= CLS_SHIFT) |=> (out_value == '0));
  // R1
  pass_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == CLS_PASS) |=> (out_flags == $past(in_a_lo)));
  // R2
  nz_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls != CLS_PASS) |=> !(out_flags[3] && out_flags[2]));
  // R2
  x_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls != CLS_PASS && in_cls <= CLS_SHIFT) |=> (out_flags[4] == $past(in_x)));
  // R8
  shift_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == CLS_SHIFT) |=> (out_flags[0] == ($past(in_b) != '0)));
  // R9
  chain_xc_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_cls == CLS_XADD || in_cls == CLS_XSUB)) |=> (out_flags[4] == out_flags[0]));
  // R10
  sticky_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_cls == CLS_XADD || in_cls == CLS_XSUB) && !in_zprev) |=> !out_flags[2]);
  // R11
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls > CLS_XSUB) |=> (out_err && out_flags == '0 && out_value == '0));
  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_err |=> !out_err || $past(in_valid && in_cls > CLS_XSUB));
endmodule

bind lazy_flag_unit lazy_flag_unit_chk #(.W(W)) u_lazy_flag_unit_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
  .in_a_lo(in_a[lazy_flag_pkg::FLAG_W-1:0]), .in_b(in_b), .in_x(in_x),
  .in_zprev(in_zprev), .out_valid(out_valid), .out_flags(out_flags),
  .out_value(out_value), .out_err(out_err)
);

// File: tb/test_lazy_flag_unit.sv
`timescale 1ns/1ps
module test_lazy_flag_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         in_valid = 1'b0;
  logic [3:0]   in_cls = '0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         in_x = 1'b0, in_zprev = 1'b0;
  logic         out_valid, out_err;
  logic [4:0]   out_flags;
  logic [W-1:0] out_value;

  lazy_flag_unit #(.W(W)) i_lazy_flag_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
    .in_a(in_a), .in_b(in_b), .in_x(in_x), .in_zprev(in_zprev),
    .out_valid(out_valid), .out_flags(out_flags),
    .out_value(out_value), .out_err(out_err)
  );

  typedef struct {
    logic [4:0]   f;
    logic [W-1:0] val;
    logic         err;
    string        tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int checks = 0;
  int fails  = 0;

  function automatic logic [4:0] pk(logic x, logic n, logic z, logic v, logic c);
    return {x, n, z, v, c};
  endfunction

  task automatic send(logic [3:0] cls, logic [W-1:0] a, logic [W-1:0] b, logic x, logic zp,
                      logic [4:0] ef, logic [W-1:0] ev, logic ee, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_cls = cls; in_a = a; in_b = b; in_x = x; in_zprev = zp;
    e.f = ef; e.val = ev; e.err = ee; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // R4: record built from a real addition a + b
  task automatic t_add(logic [W-1:0] a, logic [W-1:0] b, logic x);
    logic [W:0] s = {1'b0, a} + {1'b0, b};
    logic [W-1:0] r = s[W-1:0];
    logic v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    send(4'd2, r, b, x, 1'b0, pk(x, r[W-1], r == 0, v, s[W]), '0, 1'b0, "R4 add");
  endtask

  // R5: record built from a real subtraction a - b
  task automatic t_sub(logic [W-1:0] a, logic [W-1:0] b, logic x);
    logic [W-1:0] r = a - b;
    logic v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    send(4'd3, r, b, x, 1'b0, pk(x, r[W-1], r == 0, v, a < b), '0, 1'b0, "R5 sub");
  endtask

  // R7: add with extend, a + b + 1
  task automatic t_addx(logic [W-1:0] a, logic [W-1:0] b, logic x);
    logic [W:0] s = {1'b0, a} + {1'b0, b} + 1;
    logic [W-1:0] r = s[W-1:0];
    logic v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    send(4'd6, r, b, x, 1'b0, pk(x, r[W-1], r == 0, v, s[W]), '0, 1'b0, "R7 addx");
  endtask

  // R7: subtract with extend, a - b - 1
  task automatic t_subx(logic [W-1:0] a, logic [W-1:0] b, logic x);
    logic [W-1:0] r = a - b - 1;
    logic v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    send(4'd7, r, b, x, 1'b0, pk(x, r[W-1], r == 0, v, a <= b), '0, 1'b0, "R7 subx");
  endtask

  // R6: narrow compare, upper bits filled with junk
  task automatic t_cmp(logic word, logic [15:0] a, logic [15:0] b, logic x);
    logic [W-1:0] junk_r = $urandom();
    logic [W-1:0] junk_o = $urandom();
    logic [15:0] r16 = a - b;
    logic [7:0]  r8  = a[7:0] - b[7:0];
    logic [W-1:0] rr, oo;
    logic n, z, v, c;
    if (word) begin
      rr = {junk_r[W-1:16], r16}; oo = {junk_o[W-1:16], b};
      n = r16[15]; z = (r16 == 0); c = a < b;
      v = (a[15] != b[15]) && (r16[15] != a[15]);
    end else begin
      rr = {junk_r[W-1:8], r8}; oo = {junk_o[W-1:8], b[7:0]};
      n = r8[7]; z = (r8 == 0); c = a[7:0] < b[7:0];
      v = (a[7] != b[7]) && (r8[7] != a[7]);
    end
    send(word ? 4'd5 : 4'd4, rr, oo, x, 1'b0, pk(x, n, z, v, c), '0, 1'b0, "R6 compare");
  endtask

  // R9 R10: chained add or subtract
  task automatic t_chain(logic sub, logic [W-1:0] a, logic [W-1:0] b, logic x, logic zp);
    logic [W:0] s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, x};
    logic [W-1:0] r;
    logic c, v;
    if (sub) begin
      r = a - b - {{(W-1){1'b0}}, x};
      c = x ? (a <= b) : (a < b);
      v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    end else begin
      r = s[W-1:0];
      c = s[W];
      v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    end
    send(sub ? 4'd10 : 4'd9, a, b, x, zp, pk(c, r[W-1], (r == 0) && zp, v, c), r, 1'b0,
         "R9 R10 chain");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected response flags=%b expected none", out_flags);
      end else begin
        cur = q.pop_front();
        if (out_flags !== cur.f || out_value !== cur.val || out_err !== cur.err) begin
          fails++;
          $display("FAIL %s actual flags=%b value=%h err=%b expected flags=%b value=%h err=%b",
                   cur.tag, out_flags, out_value, out_err, cur.f, cur.val, cur.err);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R12 watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_flags !== 5'd0 || out_value !== '0 || out_err !== 1'b0) begin
      fails++;
      $display("FAIL R12 reset actual valid=%b flags=%b err=%b expected 0 0 0",
               out_valid, out_flags, out_err);
    end
    rst = 1'b0;
    idle(1);

    // R1 pass-through
    send(4'd0, 32'hABCD_0015, 32'h0, 1'b0, 1'b0, 5'b10101, '0, 1'b0, "R1 pass");
    send(4'd0, 32'h0000_000A, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'b01010, '0, 1'b0, "R1 pass");
    // R3 logic, R2 N/Z
    send(4'd1, 32'h0, 32'h1234, 1'b1, 1'b0, pk(1, 0, 1, 0, 0), '0, 1'b0, "R3 R2 logic zero");
    send(4'd1, 32'h8000_0000, 32'h0, 1'b0, 1'b0, pk(0, 1, 0, 0, 0), '0, 1'b0, "R3 R2 logic neg");
    // R4 corners
    t_add(32'hFFFF_FFFF, 32'h1, 1'b0);
    t_add(32'h7FFF_FFFF, 32'h1, 1'b1);
    t_add(32'h8000_0000, 32'h8000_0000, 1'b0);
    t_add(32'h0000_1234, 32'h0000_0001, 1'b0);
    // R5 corners
    t_sub(32'h8000_0000, 32'h1, 1'b0);
    t_sub(32'h5, 32'h5, 1'b1);
    t_sub(32'h0, 32'h1, 1'b0);
    // R7 corners
    t_addx(32'h0, 32'hFFFF_FFFF, 1'b0);
    t_addx(32'h7FFF_FFFF, 32'h0, 1'b1);
    t_subx(32'h5, 32'h5, 1'b0);
    t_subx(32'h8000_0000, 32'h0, 1'b1);
    t_subx(32'h6, 32'h5, 1'b0);
    // R6 compares
    t_cmp(1'b0, 16'h0042, 16'h0042, 1'b0);
    t_cmp(1'b0, 16'h0080, 16'h0001, 1'b1);
    t_cmp(1'b0, 16'h0001, 16'h0002, 1'b0);
    t_cmp(1'b1, 16'h8000, 16'h0001, 1'b0);
    t_cmp(1'b1, 16'h1234, 16'h1234, 1'b1);
    // R8 shift
    send(4'd8, 32'h0, 32'h1, 1'b0, 1'b0, pk(0, 0, 1, 0, 1), '0, 1'b0, "R8 shift carry");
    send(4'd8, 32'hF000_0000, 32'h0, 1'b1, 1'b0, pk(1, 1, 0, 0, 0), '0, 1'b0, "R8 shift no carry");
    // R11 unknown codes
    send(4'd11, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b1, 5'd0, '0, 1'b1, "R11 bad code");
    send(4'd15, 32'h1F, 32'h0, 1'b1, 1'b1, 5'd0, '0, 1'b1, "R11 bad code");
    send(4'd1, 32'h1, 32'h0, 1'b0, 1'b0, pk(0, 0, 0, 0, 0), '0, 1'b0, "R11 err drops");
    // R9 R10 chains: zero total, then non-zero low word
    t_chain(1'b0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1);
    t_chain(1'b0, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b1);
    t_chain(1'b0, 32'h5, 32'h0, 1'b0, 1'b1);
    t_chain(1'b0, 32'h0, 32'h0, 1'b0, 1'b0);
    t_chain(1'b1, 32'h0, 32'h1, 1'b0, 1'b1);
    t_chain(1'b1, 32'h1, 32'h0, 1'b1, 1'b1);
    t_chain(1'b1, 32'h0, 32'h0, 1'b1, 1'b0);
    t_chain(1'b1, 32'h8000_0000, 32'h0, 1'b1, 1'b1);
    idle(2);
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] ra, rb;
      logic rx;
      ra = $urandom(); rb = $urandom(); rx = $urandom_range(1);
      case (i % 7)
        0: t_add(ra, rb, rx);
        1: t_sub(ra, rb, rx);
        2: t_addx(ra, rb, rx);
        3: t_subx(ra, rb, rx);
        4: t_cmp(ra[0], ra[15:0], rb[15:0], rx);
        5: t_chain(1'b0, ra, rb, rx, rb[3]);
        default: t_chain(1'b1, ra, rb, rx, ra[5]);
      endcase
    end
    idle(3);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R12 missing responses actual=%0d expected=0", q.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule